// File: doc/BRIEF.md
# Self-Purging Threshold Voter

This block merges the single-bit results of several replicated modules into one voted bit. Each module carries a one-bit weight held in an internal mask. The weight is 1 while the module is trusted and 0 once it has been removed. The voted bit is 1 exactly when more than half of the trusted modules currently drive 1. Inputs from removed modules count as 0 and do not enter the count of trusted modules, so the threshold shrinks as the group shrinks.

A trusted module whose bit differs from the voted bit in a cycle is dropped from the mask at the next clock edge, and it stays dropped until reset. A diagnostic pulse marks that event for each module. When only two trusted modules are left and they disagree, no majority exists. The block then keeps both modules, drives 0 and raises a no-majority flag.

Top module: `purge_voter`

## Requirements
- R1: During and after a synchronous reset (rst high at a clock edge) every bit of `trust_mask` is 1.
- R2: `voted` is 1 exactly when the number of modules with `trust_mask` bit 1 and `mod_bits` bit 1 is at least floor(T/2)+1, where T is the number of 1 bits in `trust_mask`. Bits of modules with mask bit 0 have no effect on `voted`.
- R3: When T is 3 or more, every module with mask bit 1 whose input differs from `voted` has its `purge_evt` bit high in that cycle and its mask bit cleared at the next clock edge. No other mask bit changes.
- R4: `voted`, `purge_evt` and `no_majority` in a cycle depend on the mask held before that cycle's edge, so the purge shows in `trust_mask` one cycle after `purge_evt`.
- R5: A cleared mask bit stays 0 until reset, and `purge_evt` is never high for a module whose mask bit is 0.
- R6: When T is 2 or less and the trusted modules disagree, `no_majority` is 1, `voted` is 0, `purge_evt` is all zero and the mask is unchanged. Otherwise `no_majority` is 0.
- R7: With an even T of 4 or more and exactly T/2 trusted modules at 1, `voted` is 0 and the modules at 1 are purged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mod_bits | input | NMOD | One result bit per replicated module |
| voted | output | 1 | Strict-majority vote over trusted modules |
| trust_mask | output | NMOD | Registered weight per module, 1 = trusted |
| purge_evt | output | NMOD | High in the cycle a module is judged faulty |
| no_majority | output | 1 | Two or fewer trusted modules that disagree |

## Verification
A mask bit that is wrongly cleared or kept shows up in `trust_mask` one cycle after the vote that should have set it. It also changes the threshold, so later votes and purge pulses are wrong as soon as a pattern splits the trusted modules differently. A wrong threshold or count shows in `voted` in the same cycle as the input pattern. Comparing every output on every cycle against an independent model catches either kind of fault within one clock of its first visible effect.

// File: rtl/pv_pkg.sv
package pv_pkg;
   // bits needed to hold a count from 0 to n
   function automatic int cnt_bits(input int n);
      return (n < 1) ? 1 : $clog2(n + 1);
   endfunction
endpackage

// File: rtl/pv_popcount.sv
module pv_popcount #(
   parameter int N  = 5,
   parameter int CW = 3
) (
   input  logic [N-1:0]  vec,
   output logic [CW-1:0] count
);
   generate
      if (N == 1) begin : g_single
         assign count = CW'(vec[0]);
      end else begin : g_sum
         always_comb begin
            count = '0;
            for (int i = 0; i < N; i++) count = count + CW'(vec[i]);
         end
      end
   endgenerate
endmodule

// File: rtl/pv_threshold.sv
module pv_threshold #(
   parameter int CW = 3
) (
   input  logic [CW-1:0] ones,
   input  logic [CW-1:0] trusted,
   output logic          vote
);
   logic [CW-1:0] need;
   assign need = (trusted >> 1) + CW'(1);
   assign vote = (trusted != '0) && (ones >= need);

   always_comb begin
      // R2 (check): a vote of 1 always needs at least one trusted 1
      if (vote) assert (ones != '0) else $error("p_vote_needs_one_r2");
   end
endmodule

// File: rtl/pv_mask_reg.sv
module pv_mask_reg #(
   parameter int N = 5
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [N-1:0] drop,
   output logic [N-1:0] mask
);
   generate
      for (genvar g = 0; g < N; g++) begin : g_bit
         always_ff @(posedge clk) begin
            if (rst)          mask[g] <= 1'b1;
            else if (drop[g]) mask[g] <= 1'b0;
         end

         p_sticky_r5: assert property (@(posedge clk) disable iff (rst)
            !mask[g] |=> !mask[g]);
      end
   endgenerate

   p_reset_full_r1: assert property (@(posedge clk)
      rst |=> (mask == {N{1'b1}}));
endmodule

// File: rtl/purge_voter.sv
module purge_voter #(
   parameter int NMOD = 5
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [NMOD-1:0] mod_bits,
   output logic            voted,
   output logic [NMOD-1:0] trust_mask,
   output logic [NMOD-1:0] purge_evt,
   output logic            no_majority
);
   localparam int CW = pv_pkg::cnt_bits(NMOD);

   generate
      if (NMOD < 2 || NMOD > 64) begin : g_bad_nmod
         $error("purge_voter: NMOD must lie in 2..64");
      end
   endgenerate

   logic [CW-1:0]   n_trusted, n_ones;
   logic [NMOD-1:0] odd_one;
   logic            stalemate;

   pv_popcount #(.N(NMOD), .CW(CW)) u_cnt_trust (
      .vec(trust_mask), .count(n_trusted));
   pv_popcount #(.N(NMOD), .CW(CW)) u_cnt_ones (
      .vec(trust_mask & mod_bits), .count(n_ones));

   pv_threshold #(.CW(CW)) u_thr (
      .ones(n_ones), .trusted(n_trusted), .vote(voted));

   assign odd_one     = trust_mask & (mod_bits ^ {NMOD{voted}});
   assign stalemate   = (n_trusted <= CW'(2)) && (odd_one != '0);
   assign no_majority = stalemate || (n_trusted == '0);
   assign purge_evt   = stalemate ? '0 : odd_one;

   pv_mask_reg #(.N(NMOD)) u_mask (
      .clk(clk), .rst(rst), .drop(purge_evt), .mask(trust_mask));

   p_pulse_clears_r3: assert property (@(posedge clk) disable iff (rst)
      (purge_evt != '0) |=> ((trust_mask & $past(purge_evt)) == '0));
   p_pulse_trusted_r5: assert property (@(posedge clk) disable iff (rst)
      (purge_evt & ~trust_mask) == '0);
   p_hold_keeps_r6: assert property (@(posedge clk) disable iff (rst)
      no_majority |=> $stable(trust_mask));
   p_hold_low_r6: assert property (@(posedge clk) disable iff (rst)
      no_majority |-> !voted);
endmodule

// File: tb/purge_voter_test.sv
module purge_voter_test;
   localparam int N = 5;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic [N-1:0] mod_bits = '0;
   logic         voted, no_majority;
   logic [N-1:0] trust_mask, purge_evt;

   int total = 0;
   int bad   = 0;
   logic [N-1:0] m_mask;
   logic [15:0]  lfsr = 16'hACE1;

   always #2 clk = ~clk;  // 250 MHz

   purge_voter #(.NMOD(N)) uut (
      .clk(clk), .rst(rst), .mod_bits(mod_bits), .voted(voted),
      .trust_mask(trust_mask), .purge_evt(purge_evt), .no_majority(no_majority));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
      end
   endtask

   task automatic finish_run();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   // one cycle: drive at negedge, compare combinational outputs, then model edge
   task automatic step(input logic [N-1:0] bits, input logic r);
      int t, o;
      logic ev, hold;
      logic [N-1:0] dis, ep;
      @(negedge clk);
      rst = r;
      mod_bits = bits;
      #1;
      t = 0; o = 0;
      for (int i = 0; i < N; i++) begin
         t += m_mask[i];
         o += (m_mask[i] & bits[i]);
      end
      ev = (2 * o > t);
      dis = m_mask & (bits ^ {N{ev}});
      hold = (t <= 2) && (dis != 0);
      ep = hold ? '0 : dis;
      chk("R3 R5 mask", 32'(trust_mask), 32'(m_mask));
      chk("R2 R4 voted", 32'(voted), 32'(ev));
      chk("R3 R4 purge_evt", 32'(purge_evt), 32'(ep));
      chk("R6 no_majority", 32'(no_majority), 32'(hold || t == 0));
      m_mask = r ? {N{1'b1}} : (m_mask & ~ep);
   endtask

   initial begin
      #200000;
      bad++;
      $display("FAIL watchdog actual=running expected=done");
      finish_run();
   end

   initial begin
      repeat (2) @(posedge clk);
      m_mask = {N{1'b1}};
      step('0, 1'b1);
      // R1: mask full after reset
      chk("R1 reset mask", 32'(trust_mask), 32'h1F);
      step(5'b11111, 1'b0);
      // R3 R4: module 3 disagrees; vote still uses five-module mask
      step(5'b10111, 1'b0);
      chk("R3 pulse bit3", 32'(purge_evt), 32'h08);
      #2;
      chk("R4 mask after edge", 32'(trust_mask), 32'h17);
      // R2 R5: purged module 3 driving 1 alone is ignored
      step(5'b01000, 1'b0);
      chk("R5 no pulse on purged", 32'(purge_evt[3]), 32'h0);
      chk("R2 purged ignored", 32'(voted), 32'h0);
      step(5'b01000, 1'b0);
      // R7: 4 trusted, 2 at 1 -> vote 0, modules 0 and 1 purged
      step(5'b00011, 1'b0);
      chk("R7 tie vote", 32'(voted), 32'h0);
      chk("R7 tie purge", 32'(purge_evt), 32'h03);
      // R6: 2 trusted (bits 2 and 4) disagree
      step(5'b00100, 1'b0);
      chk("R6 flag", 32'(no_majority), 32'h1);
      chk("R6 vote low", 32'(voted), 32'h0);
      step(5'b10100, 1'b0);
      chk("R6 mask kept", 32'(trust_mask), 32'h14);
      chk("R6 agree clears flag", 32'(no_majority), 32'h0);
      // R1: reset restores full trust
      step('0, 1'b1);
      step('0, 1'b0);
      chk("R1 re-reset", 32'(trust_mask), 32'h1F);
      // mixed patterns with periodic resets
      for (int c = 0; c < 4000; c++) begin
         logic [N-1:0] p;
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         p = lfsr[0] ? {N{1'b1}} : '0;
         if (lfsr[4:2] == 3'd0) p[lfsr[9:6] % N] = ~p[lfsr[9:6] % N];
         if (lfsr[4:2] == 3'd1) begin
            p[lfsr[9:6] % N]   = ~p[lfsr[9:6] % N];
            p[lfsr[13:10] % N] = ~p[lfsr[13:10] % N];
         end
         if (lfsr[4:2] == 3'd2) p = lfsr[15:11];
         step(p, (c % 50) == 49);
      end
      finish_run();
   end
endmodule